// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Codec

This block protects a 16-bit data word with five check bits, which gives a 21-bit codeword. The encoder side takes a data word and returns the codeword. The decoder side takes a codeword that may have been corrupted. It recomputes the parity groups, repairs a single flipped bit and returns the repaired data. It also returns the syndrome and two status flags. Both sides are purely combinational up to a single output register stage. A result appears on the outputs one rising clock edge after its input was presented. There is no handshake.

Codeword positions are counted from 1. Position p is carried on vector bit p-1. The powers of two (1, 2, 4, 8, 16) hold check bits. Every other position holds a data bit, filled in ascending order. A position belongs to every parity group whose power of two appears in its binary form. The syndrome is formed by setting bit j when group 2^j has odd parity. For a single flip, the syndrome therefore equals the number of the flipped position. The number of check bits is derived from the data width as the smallest r with m + r + 1 <= 2^r.

There is no state machine. The block is a pipeline of one register stage, reset synchronously.

Top module: `hsec_codec`

## Requirements
- R1: The encoder places data bit i at the i-th non-power-of-two position. Data bit 0 goes to position 3, bit 1 to position 5, bit 4 to position 9 and bit 15 to position 21. Positions 1, 2, 4, 8 and 16 carry check bits.
- R2: Every check bit at position 2^j gives even parity over all positions p whose bit j is set, so a freshly encoded word has syndrome 0.
- R3: `enc_code_o` shows the encoding of the `enc_data_i` value sampled at the previous rising edge of `clk`.
- R4: A decoded word with syndrome 0 returns its data field unchanged, with `dec_err_o` and `dec_uncorr_o` both low.
- R5: When exactly one data position p of a valid codeword is flipped, `dec_syndrome_o` equals p, `dec_data_o` equals the original data and `dec_err_o` is high.
- R6: When exactly one check position (1, 2, 4, 8 or 16) is flipped, `dec_syndrome_o` equals that position, `dec_data_o` equals the original data and `dec_err_o` is high.
- R7: A syndrome from 22 to 31 sets `dec_uncorr_o` high and `dec_err_o` low, and `dec_data_o` is the received data field with no bit flipped.
- R8: While `rst` is high at a rising edge, every output is cleared to zero on that edge, whatever the inputs are.
- R9: Decoder outputs reflect the `dec_code_i` value sampled at the previous rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 16 | Data word to encode |
| enc_code_o | output | 21 | Registered codeword, position p on bit p-1 |
| dec_code_i | input | 21 | Received codeword, position p on bit p-1 |
| dec_data_o | output | 16 | Registered repaired data |
| dec_syndrome_o | output | 5 | Registered syndrome, equals the flipped position for a single error |
| dec_err_o | output | 1 | Registered flag: a single error in positions 1 to 21 was found and repaired |
| dec_uncorr_o | output | 1 | Registered flag: syndrome lies outside the codeword, nothing repaired |

## Verification
The bench encodes table and random words, then flips every one of the 21 positions in turn. This exposes a misplaced data bit or a wrong group mask: the syndrome would then differ from the flipped position, or the wrong data bit would be repaired. Flips at the five check positions confirm that the data comes back untouched even though the error flag rises. Pairs of flips chosen to give syndromes 22 and above catch two faults: a design that repairs a bit outside the codeword, and one that raises the plain error flag instead of the uncorrectable one. A reset asserted in the middle of traffic with nonzero inputs shows whether the outputs clear on the same edge.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    localparam int MAXPOS = 64;

    function automatic int chk_count(int m);
        int r;
        r = 0;
        while ((1 << r) < m + r + 1) r++;
        return r;
    endfunction

    function automatic bit is_pow2(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Position (1-based) of the idx-th data bit in the codeword
    function automatic int data_pos(int idx);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int p = 1; p < MAXPOS; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == idx && res == 0) res = p;
                cnt++;
            end
        end
        return res;
    endfunction

    // Membership mask of parity group 2^j over positions 1..n (bit p-1)
    function automatic logic [MAXPOS-1:0] grp_mask(int j, int n);
        logic [MAXPOS-1:0] m;
        m = '0;
        for (int p = 1; p < MAXPOS; p++) begin
            if (p <= n && ((p >> j) & 1) == 1) m[p-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5,
    parameter int CODE_W = 21
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] placed;
    logic [CHK_W-1:0]  par;

    for (genvar j = 0; j < CHK_W; j++) begin : g_chk_zero
        assign placed[(1 << j) - 1] = 1'b0;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_place
        localparam int POS = hsec_pkg::data_pos(i);
        assign placed[POS-1] = data_i[i];
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_par
        localparam logic [hsec_pkg::MAXPOS-1:0] MF = hsec_pkg::grp_mask(j, CODE_W);
        assign par[j] = ^(placed & MF[CODE_W-1:0]);
    end

    always_comb begin
        code_o = placed;
        for (int j = 0; j < CHK_W; j++) begin
            code_o[(1 << j) - 1] = par[j];
        end
    end

endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
    parameter int CHK_W  = 5,
    parameter int CODE_W = 21
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o
);

    for (genvar j = 0; j < CHK_W; j++) begin : g_grp
        localparam logic [hsec_pkg::MAXPOS-1:0] MF = hsec_pkg::grp_mask(j, CODE_W);
        assign syn_o[j] = ^(code_i & MF[CODE_W-1:0]);
    end

endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5,
    parameter int CODE_W = 21
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o,
    output logic              uncorr_o
);

    localparam logic [CHK_W-1:0] TOP_POS = CHK_W'(CODE_W);

    logic              in_range;
    logic [CODE_W-1:0] fixed;

    assign in_range = (syn_i != '0) && (syn_i <= TOP_POS);
    assign err_o    = in_range;
    assign uncorr_o = (syn_i > TOP_POS);

    always_comb begin
        fixed = code_i;
        for (int p = 0; p < CODE_W; p++) begin
            if (in_range && syn_i == CHK_W'(p + 1)) fixed[p] = ~code_i[p];
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_pick
        localparam int POS = hsec_pkg::data_pos(i);
        assign data_o[i] = fixed[POS-1];
    end

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
    parameter int DATA_W = 16,
    localparam int CHK_W  = hsec_pkg::chk_count(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syndrome_o,
    output logic              dec_err_o,
    output logic              dec_uncorr_o
);

    logic [CODE_W-1:0] enc_code_c;
    logic [CHK_W-1:0]  syn_c;
    logic [DATA_W-1:0] data_c;
    logic              err_c;
    logic              uncorr_c;

    hsec_encoder #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .CODE_W (CODE_W)
    ) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    hsec_syndrome #(
        .CHK_W  (CHK_W),
        .CODE_W (CODE_W)
    ) u_syn (
        .code_i (dec_code_i),
        .syn_o  (syn_c)
    );

    hsec_corrector #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .CODE_W (CODE_W)
    ) u_fix (
        .code_i   (dec_code_i),
        .syn_i    (syn_c),
        .data_o   (data_c),
        .err_o    (err_c),
        .uncorr_o (uncorr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_code_o     <= '0;
            dec_data_o     <= '0;
            dec_syndrome_o <= '0;
            dec_err_o      <= 1'b0;
            dec_uncorr_o   <= 1'b0;
        end else begin
            enc_code_o     <= enc_code_c;
            dec_data_o     <= data_c;
            dec_syndrome_o <= syn_c;
            dec_err_o      <= err_c;
            dec_uncorr_o   <= uncorr_c;
        end
    end

endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 5,
    parameter int CODE_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CODE_W-1:0] enc_code_o,
    input logic [CODE_W-1:0] dec_code_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CHK_W-1:0]  dec_syndrome_o,
    input logic              dec_err_o,
    input logic              dec_uncorr_o
);

    localparam logic [CHK_W-1:0] TOP_POS = CHK_W'(CODE_W);

    logic [CHK_W-1:0]  enc_syn;
    logic [CHK_W-1:0]  in_syn;
    logic [DATA_W-1:0] enc_field;
    logic [DATA_W-1:0] in_field;
    logic              rst_d;

    // Syndrome as XOR of the position numbers of all set bits
    always_comb begin
        enc_syn = '0;
        in_syn  = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (enc_code_o[p-1]) enc_syn = enc_syn ^ CHK_W'(p);
            if (dec_code_i[p-1]) in_syn  = in_syn ^ CHK_W'(p);
        end
    end

    always_comb begin
        int k;
        k = 0;
        enc_field = '0;
        in_field  = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!hsec_pkg::is_pow2(p) && k < DATA_W) begin
                enc_field[k] = enc_code_o[p-1];
                in_field[k]  = dec_code_i[p-1];
                k++;
            end
        end
    end

    always_ff @(posedge clk) rst_d <= rst;

    always @(negedge clk) begin
        if (rst_d === 1'b1) begin
            AST_RESET_CLEARS: assert (enc_code_o == '0 && dec_data_o == '0 && dec_syndrome_o == '0
                                      && !dec_err_o && !dec_uncorr_o); // R8
        end
    end

    AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
        enc_syn == '0); // R2

    AST_ENC_FIELD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> enc_field == $past(enc_data_i)); // R3

    AST_SYN_MATCH: assert property (@(posedge clk) disable iff (rst)
        !rst |=> dec_syndrome_o == $past(in_syn)); // R9

    AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_syn == '0) |=> (dec_data_o == $past(in_field) && !dec_err_o && !dec_uncorr_o)); // R4

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
        (dec_syndrome_o > TOP_POS) |-> (dec_uncorr_o && !dec_err_o)); // R7

    AST_SINGLE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (dec_syndrome_o != '0 && dec_syndrome_o <= TOP_POS) |-> (dec_err_o && !dec_uncorr_o)); // R5

endmodule

bind hsec_codec hsec_codec_chk #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .enc_data_i     (enc_data_i),
    .enc_code_o     (enc_code_o),
    .dec_code_i     (dec_code_i),
    .dec_data_o     (dec_data_o),
    .dec_syndrome_o (dec_syndrome_o),
    .dec_err_o      (dec_err_o),
    .dec_uncorr_o   (dec_uncorr_o)
);

// File: tb/hsec_codec_test.sv
`timescale 1ns/1ps
module hsec_codec_test;

    localparam int DW = 16;
    localparam int CW = 21;
    localparam int RW = 5;
    localparam int NVEC = 8;
    localparam int NRAND = 12;

    // {data, flipped position (0 = none)}
    localparam logic [DW+RW-1:0] VEC [NVEC] = '{
        {16'h0000, 5'd0},
        {16'hFFFF, 5'd0},
        {16'h0001, 5'd3},
        {16'h8000, 5'd21},
        {16'hA5A5, 5'd11},
        {16'h1234, 5'd16},
        {16'hFFFF, 5'd1},
        {16'h0F0F, 5'd8}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] enc_data_i = '0;
    logic [CW-1:0] enc_code_o;
    logic [CW-1:0] dec_code_i = '0;
    logic [DW-1:0] dec_data_o;
    logic [RW-1:0] dec_syndrome_o;
    logic          dec_err_o;
    logic          dec_uncorr_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    hsec_codec uut (
        .clk            (clk),
        .rst            (rst),
        .enc_data_i     (enc_data_i),
        .enc_code_o     (enc_code_o),
        .dec_code_i     (dec_code_i),
        .dec_data_o     (dec_data_o),
        .dec_syndrome_o (dec_syndrome_o),
        .dec_err_o      (dec_err_o),
        .dec_uncorr_o   (dec_uncorr_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic bit pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CW-1:0] ref_enc(logic [DW-1:0] d);
        logic [CW-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p <= CW; p++) begin
            if (!pow2(p)) begin
                c[p-1] = d[k];
                k++;
            end
        end
        for (int j = 0; j < RW; j++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW; p++) if (((p >> j) & 1) == 1) par = par ^ c[p-1];
            c[(1 << j) - 1] = par;
        end
        return c;
    endfunction

    function automatic logic [DW-1:0] ref_field(logic [CW-1:0] c);
        logic [DW-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CW; p++) begin
            if (!pow2(p)) begin
                d[k] = c[p-1];
                k++;
            end
        end
        return d;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h, expected %h", tag, act, exp);
        end
    endtask

    // Apply one encode and one decode; results are checked one edge later
    task automatic apply(logic [DW-1:0] d, logic [CW-1:0] cin,
                         logic [DW-1:0] exp_d, logic [RW-1:0] exp_s,
                         logic exp_e, logic exp_u, string tag);
        @(negedge clk);
        enc_data_i = d;
        dec_code_i = cin;
        @(negedge clk);
        check({tag, " R1 R2 R3 code"}, 64'(enc_code_o), 64'(ref_enc(d)));
        check({tag, " R9 data"},       64'(dec_data_o), 64'(exp_d));
        check({tag, " R9 syndrome"},   64'(dec_syndrome_o), 64'(exp_s));
        check({tag, " flags"},         64'({dec_err_o, dec_uncorr_o}), 64'({exp_e, exp_u}));
    endtask

    task automatic single(logic [DW-1:0] d, int f);
        logic [CW-1:0] c;
        string tag;
        c = ref_enc(d);
        if (f != 0) c[f-1] = ~c[f-1];
        if (f == 0) tag = "R4 clean";
        else if (pow2(f)) tag = "R6 check-bit flip";
        else tag = "R5 data-bit flip";
        apply(d, c, d, RW'(f), f != 0, 1'b0, tag);
    endtask

    task automatic double(logic [DW-1:0] d, int a, int b);
        logic [CW-1:0] c;
        c = ref_enc(d);
        c[a-1] = ~c[a-1];
        c[b-1] = ~c[b-1];
        apply(d, c, ref_field(c), RW'(a ^ b), 1'b0, 1'b1, "R7 out-of-range syndrome");
    endtask

    initial begin
        // R8: reset holds outputs at zero with busy inputs
        enc_data_i = 16'hBEEF;
        dec_code_i = 21'h1FFFFF;
        @(negedge clk);
        @(negedge clk);
        check("R8 reset enc", 64'(enc_code_o), 64'd0);
        check("R8 reset dec", 64'({dec_data_o, dec_syndrome_o, dec_err_o, dec_uncorr_o}), 64'd0);
        rst = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            single(VEC[v][DW+RW-1:RW], int'(VEC[v][RW-1:0]));
        end

        for (int r = 0; r < NRAND; r++) begin
            logic [DW-1:0] d;
            d = DW'($urandom());
            for (int f = 0; f <= CW; f++) single(d, f);
        end

        double(16'h5A5A, 21, 3);
        double(16'h0000, 21, 10);
        double(16'hFFFF, 20, 2);
        double(16'h1357, 16, 7);
        double(16'hC3C3, 17, 13);

        // R8: reset in the middle of traffic clears on the same edge
        @(negedge clk);
        enc_data_i = 16'h7777;
        dec_code_i = ref_enc(16'h7777) ^ 21'h000010;
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run reset enc", 64'(enc_code_o), 64'd0);
        check("R8 mid-run reset dec", 64'({dec_data_o, dec_syndrome_o, dec_err_o, dec_uncorr_o}), 64'd0);
        rst = 1'b0;
        single(16'h7777, 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule